// File: doc/BRIEF.md
# Column Mixing Unit for a Wide-Pipe Hash Round

This block performs the column diffusion step of a wide-pipe hash permutation on one column of eight bytes. The product is a circulant matrix times the column over GF(2^8). It is not built from one multiplier per coefficient. Instead, a shared network of XOR terms feeds two rows of byte doublings. A round unit places one copy of this block per column and per permutation. The substitution and byte-rotation steps are outside this block.

The column enters and leaves as a 64-bit word, with byte 0 in bits 7:0. Both sides use valid/ready handshakes.

With `REG_OUT = 1` (the default), the result sits in one output register. Back-pressure works as follows:
- `in_ready` is high whenever that register is empty or is being drained in the same cycle.
- A held result does not change while `out_ready` is low.

With `REG_OUT = 0`, the block is purely combinational:
- valid passes straight from input to output.
- ready passes straight from output to input.

Top module: `col_mix_unit`

## Requirements
- R1: Output byte i equals 02·a[i] ⊕ 02·a[i+1] ⊕ 03·a[i+2] ⊕ 04·a[i+3] ⊕ 05·a[i+4] ⊕ 03·a[i+5] ⊕ 05·a[i+6] ⊕ 07·a[i+7]. Indices are modulo 8, and byte k occupies bits 8k+7:8k of both `in_data` and `out_data`.
- R2: Multiplication by 02 shifts the byte left by one and XORs in 0x1B when the discarded top bit was 1. For example, a column of all 0x80 gives all 0x9B.
- R3: An all-zero column produces an all-zero result.
- R4: With `REG_OUT = 1`, a column accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high after that edge.
- R5: With `REG_OUT = 1`, `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R6: While `rst_n` is low, `out_valid` is low. With `REG_OUT = 1`, `in_ready` is high during reset.
- R7: With `REG_OUT = 1`, after a result is taken (`out_valid` and `out_ready` high) with no new column accepted at that edge, `out_valid` is low in the next cycle.
- R8: With `REG_OUT = 0`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, and `out_data` is the R1 result of the present `in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input column valid |
| in_ready | output | 1 | Block can take a column |
| in_data | input | 64 | Input column, byte 0 in low bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Mixed column, byte 0 in low bits |

## Verification
The bound checker watches the handshake on every cycle:
- the ready rule;
- holding of the result under back-pressure;
- the one-cycle appearance of an accepted column;
- the drop of valid after draining;
- a zero column producing zero.

The arithmetic cannot be seen by a property. Correctness of the circulant coefficients and of the 0x1B reduction rests on the bench's scenarios:
- hand-worked single-byte and uniform columns;
- pseudo-random columns compared with a plain shift-and-add multiplier.

The bench also covers the combinational variant.

// File: rtl/col_mix_pkg.sv
package col_mix_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 8;
  localparam int COL_W  = BYTE_W * LANES;
  localparam logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [LANES-1:0] col_t;

  // multiply a field element by x (the "doubling" step)
  function automatic byte_t gf_dbl(input byte_t v);
    byte_t s;
    s = {v[BYTE_W-2:0], 1'b0};
    if (v[BYTE_W-1]) s = s ^ REDUCE_POLY;
    return s;
  endfunction
endpackage

// File: rtl/mix_dbl_stage.sv
module mix_dbl_stage
  import col_mix_pkg::*;
(
  input  col_t din,
  output col_t dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g] = gf_dbl(din[g]);
  end
endmodule

// File: rtl/mix_xor_net.sv
module mix_xor_net
  import col_mix_pkg::*;
(
  input  col_t a,
  output col_t b
);
  col_t t, x, y, z, w, v;

  for (genvar i = 0; i < LANES; i++) begin : g_pair
    assign t[i] = a[i] ^ a[(i + 1) % LANES];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_sums
    assign x[i] = t[i] ^ t[(i + 3) % LANES];
    assign y[i] = t[i] ^ t[(i + 2) % LANES] ^ a[(i + 6) % LANES];
  end

  mix_dbl_stage u_dbl_first (.din(x), .dout(z));

  for (genvar i = 0; i < LANES; i++) begin : g_mid
    assign w[i] = z[i] ^ y[(i + 4) % LANES];
  end

  mix_dbl_stage u_dbl_second (.din(w), .dout(v));

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign b[i] = v[(i + 3) % LANES] ^ y[(i + 4) % LANES];
  end
endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage
  import col_mix_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  col_t in_col,
  output logic out_valid,
  input  logic out_ready,
  output col_t out_col
);
  if (REG_OUT) begin : g_reg
    logic hold_v;
    col_t hold_d;

    assign in_ready = !hold_v || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_v <= 1'b0;
        hold_d <= '0;
      end else if (in_ready) begin
        hold_v <= in_valid;
        if (in_valid) hold_d <= in_col;
      end
    end

    assign out_valid = hold_v;
    assign out_col   = hold_d;
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_col   = in_col;
  end
endmodule

// File: rtl/col_mix_unit.sv
module col_mix_unit
  import col_mix_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COL_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COL_W-1:0]  out_data
);
  col_t col_in, col_mixed, col_out;

  assign col_in = col_t'(in_data);

  mix_xor_net u_net (.a(col_in), .b(col_mixed));

  mix_out_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_col    (col_mixed),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_col   (col_out)
  );

  assign out_data = COL_W'(col_out);
endmodule

// File: rtl/col_mix_checker.sv
module col_mix_checker
  import col_mix_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [COL_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [COL_W-1:0] out_data
);
  if (REG_OUT) begin : g_reg_chk
    p_ready_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (!out_valid || out_ready));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_data == '0) |=> (out_data == '0));
  end else begin : g_comb_chk
    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data == '0) |-> (out_data == '0));
  end
endmodule

bind col_mix_unit col_mix_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_col_mix_unit.sv
module test_col_mix_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [63:0] in_data = '0;
  logic in_ready, out_valid, c_in_ready, c_out_valid;
  logic [63:0] out_data, c_out_data;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  col_mix_unit #(.REG_OUT(1'b1)) i_col_mix_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  col_mix_unit #(.REG_OUT(1'b0)) i_col_mix_unit_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_data(in_data), .out_valid(c_out_valid), .out_ready(out_ready),
    .out_data(c_out_data));

  // stimulus, expected
  localparam logic [127:0] VEC [5] = '{
    {64'h0000000000000000, 64'h0000000000000000},
    {64'h0000000000000001, 64'h0203040503050702},
    {64'h0101010101010101, 64'h0303030303030303},
    {64'h8080808080808080, 64'h9B9B9B9B9B9B9B9B},
    {64'h0000000080000000, 64'hB69BB6AD1B1B9B36}
  };

  function automatic logic [7:0] gmul(input logic [7:0] p, input logic [7:0] q);
    logic [7:0] acc = 8'h00;
    logic [7:0] aa = p;
    for (int k = 0; k < 8; k++) begin
      if (q[k]) acc ^= aa;
      aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1B) : {aa[6:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [63:0] ref_mix(input logic [63:0] a);
    logic [7:0] coef [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] s = 8'h00;
      for (int j = 0; j < 8; j++) s ^= gmul(coef[j], a[8*((i+j)%8) +: 8]);
      r[8*i +: 8] = s;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one column, check the comb variant in-cycle and the registered one after the edge
  task automatic send(input logic [63:0] d, input logic [63:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; out_ready = 1'b1;
    #1;
    chk({tag, " R8 comb data"}, c_out_data, exp);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 out_valid after accept", {63'd0, out_valid}, 64'd1);
    chk(tag, out_data, exp);
  endtask

  initial begin
    logic [63:0] lfsr;
    logic [63:0] va, vb;
    #2;
    chk("R6 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R6 in_ready in reset", {63'd0, in_ready}, 64'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < 5; n++)
      send(VEC[n][127:64], VEC[n][63:0], n == 0 ? "R3 zero column" :
           (n >= 3 ? "R2 reduction table" : "R1 table"));

    lfsr = 64'h1234_5678_9ABC_DEF1;
    for (int n = 0; n < 24; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]} ^ (lfsr * 64'd6364136223846793005);
      send(lfsr, ref_mix(lfsr), "R1 random vs reference");
    end

    // back-pressure: R5
    va = 64'h0011_2233_4455_6677;
    vb = 64'hFEDC_BA98_7654_3210;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = va;
    @(negedge clk);
    in_data = vb;
    chk("R5 result held valid", {63'd0, out_valid}, 64'd1);
    chk("R5 first result", out_data, ref_mix(va));
    chk("R5 in_ready low while stalled", {63'd0, in_ready}, 64'd0);
    chk("R8 comb out_valid follows in_valid", {63'd0, c_out_valid}, 64'd1);
    chk("R8 comb in_ready follows out_ready", {63'd0, c_in_ready}, 64'd0);
    @(negedge clk);
    chk("R5 data stable under stall", out_data, ref_mix(va));
    out_ready = 1'b1;
    #1;
    chk("R5 in_ready high when draining", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 second taken on drain edge", out_data, ref_mix(vb));
    chk("R5 second valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R7 valid drops after drain", {63'd0, out_valid}, 64'd0);
    chk("R8 comb out_valid low", {63'd0, c_out_valid}, 64'd0);

    // reset mid-stream: R6
    in_valid = 1'b1; in_data = va; out_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 out_valid cleared by reset", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule